// File: doc/BRIEF.md
# Peripheral Clock Gating Register Bank

This block holds the on/off state of up to 64 peripheral clocks and produces one gated clock per peripheral. Software switches clocks on by writing ones to an enable word and off by writing ones to a disable word. It reads back the live state from a read-only status word. Each of these three word kinds has a low instance and a high instance. Bit `i` of the low instance and bit `i-32` of the high instance both control peripheral `i`, and that index is also the peripheral's interrupt number. A separate read/write control bit drives the enable for the coprocessor bus clock. Software must turn that enable on before any coprocessor peripheral that exchanges data with the processors.

The register port is a single-cycle strobe interface: `req_i` with `we_i` high writes `wdata_i` to the word at `addr_i`. `req_i` with `we_i` low is a read, and its data appears on `rdata_o` with `rvalid_o` one cycle later. A two-state access machine produces the read response. Its states are ACC_IDLE (no read response pending) and ACC_RESP (a read response is on the outputs). Its transitions are IDLE_TO_RESP on a read request, RESP_TO_RESP on a back-to-back read request, RESP_TO_IDLE when no read is requested, and IDLE_HOLD otherwise. Each gated clock comes from a gate whose enable latch is transparent while the clock is low. Because of this, a gated output never carries a shortened high pulse.

Word addresses: 0 enable low, 1 enable high, 2 disable low, 3 disable high, 4 status low, 5 status high, 6 coprocessor bus clock control (bit 0), 7 unmapped.

Top module: `pclk_gate_bank`

## Requirements
- R1: While and after reset, every peripheral gate state bit is 0, the bus clock control bit is 0, every gated clock output is low and `rvalid_o` is low.
- R2: A write to address 0 (or 1) sets the state of each peripheral whose bit is 1 in `wdata_i`, using bit `i` for peripheral `i` (or `32+i`). Bits written as 0 leave their state unchanged.
- R3: A write to address 2 (or 3) clears the state of each peripheral whose bit is 1 in `wdata_i`, using the same bit mapping as R2. Bits written as 0 leave their state unchanged.
- R4: A read of address 4 (or 5) returns the gate state of peripherals 0..31 (or 32..63) in bit order. A read issued in the cycle right after a write already reflects that write.
- R5: Writes to addresses 4 and 5 change no state. Reads of addresses 0 to 3 return zero.
- R6: Every gated clock output is low whenever the input clock is low.
- R7: `pclk_o[i]` follows the input clock in the high phase that starts one edge after the edge where the state of peripheral `i` became 1. It stays low from the high phase that starts one edge after the edge where the state became 0. There is no further delay.
- R8: Address 6 bit 0 is a read/write bit driven on `busclk_en_o` from the edge of the write onwards. The other bits of address 6 read as zero.
- R9: Writes to address 7 change no state, and reads of address 7 return zero.
- R10: `rvalid_o` is high for exactly the cycle after each read request, with `rdata_o` valid in that cycle. Writes never raise `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, source of all gated clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response valid |
| pclk_o | output | 64 | Gated clock per peripheral, index = peripheral id |
| busclk_en_o | output | 1 | Coprocessor bus clock enable |

## Verification
The hardest case to produce is a gate state that changes on one edge and is then reversed on the next. A test of this case has to show that the gated clock drops or starts within exactly one high phase, and that no pulse is ever shortened. The stimulus issues back-to-back enable and disable writes on adjacent edges. It also mixes those writes with status reads in the very next cycle. The high phase and the low phase of every cycle are checked against a reference model of the gate state before each edge. A long random mix of writes and reads to all eight addresses then reaches combinations that no directed step lists.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned NUM_GROUPS = 2;
    localparam int unsigned ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_EN_LO   = 3'd0,
        A_EN_HI   = 3'd1,
        A_DIS_LO  = 3'd2,
        A_DIS_HI  = 3'd3,
        A_STAT_LO = 3'd4,
        A_STAT_HI = 3'd5,
        A_BUSCLK  = 3'd6,
        A_SPARE   = 3'd7
    } reg_addr_e;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/pcg_clk_gate.sv
module pcg_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    // Enable is captured only while the clock is low, so a change can
    // never cut a high phase short.
    always_latch begin
        if (!clk_i) begin
            en_lat <= en_i;
        end
    end

    assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/pcg_gate_regs.sv
module pcg_gate_regs #(
    parameter int unsigned NUM_P = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NUM_P-1:0] set_i,
    input  logic [NUM_P-1:0] clr_i,
    input  logic             bus_we_i,
    input  logic             bus_wd_i,
    output logic [NUM_P-1:0] state_o,
    output logic             bus_o
);

    logic [NUM_P-1:0] state_q;
    logic             bus_q;

    // Clear wins over set when both hit the same bit.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= (state_q | set_i) & ~clr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bus_q <= 1'b0;
        end else if (bus_we_i) begin
            bus_q <= bus_wd_i;
        end
    end

    assign state_o = state_q;
    assign bus_o   = bus_q;

endmodule

// File: rtl/pcg_access.sv
module pcg_access
    import pcg_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned GROUPS = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_i,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [WIDTH-1:0]        wdata_i,
    input  logic [WIDTH*GROUPS-1:0] state_i,
    input  logic                    bus_i,
    output logic [WIDTH*GROUPS-1:0] set_o,
    output logic [WIDTH*GROUPS-1:0] clr_o,
    output logic                    bus_we_o,
    output logic                    bus_wd_o,
    output logic [WIDTH-1:0]        rdata_o,
    output logic                    rvalid_o
);

    localparam int unsigned NUM_P = WIDTH * GROUPS;

    acc_state_e       state_q, state_d;
    logic             rd_req;
    logic [WIDTH-1:0] rd_word;
    logic [WIDTH-1:0] rdata_q;
    reg_addr_e        acc_addr;

    assign acc_addr = reg_addr_e'(addr_i);
    assign rd_req   = req_i & ~we_i;

    // Write decode: one word per cycle, set or clear masks by group.
    always_comb begin
        set_o    = '0;
        clr_o    = '0;
        bus_we_o = 1'b0;
        bus_wd_o = wdata_i[0];
        if (req_i && we_i) begin
            unique case (acc_addr)
                A_EN_LO:  set_o[0 +: WIDTH]     = wdata_i;
                A_EN_HI:  set_o[WIDTH +: WIDTH] = wdata_i;
                A_DIS_LO: clr_o[0 +: WIDTH]     = wdata_i;
                A_DIS_HI: clr_o[WIDTH +: WIDTH] = wdata_i;
                A_BUSCLK: bus_we_o = 1'b1;
                default:  ;
            endcase
        end
    end

    // Read selection from live state.
    always_comb begin
        rd_word = '0;
        unique case (acc_addr)
            A_STAT_LO: rd_word = state_i[0 +: WIDTH];
            A_STAT_HI: rd_word = state_i[WIDTH +: WIDTH];
            A_BUSCLK:  rd_word[0] = bus_i;
            default:   rd_word = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_word;
        end
    end

    // Outputs.
    always_comb begin
        rvalid_o = 1'b0;
        rdata_o  = '0;
        unique case (state_q)
            ACC_RESP: begin
                rvalid_o = 1'b1;
                rdata_o  = rdata_q;
            end
            default: ;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{NUM_P[0]};

endmodule

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank
    import pcg_pkg::*;
#(
    parameter int unsigned WIDTH  = pcg_pkg::WORD_W,
    parameter int unsigned GROUPS = pcg_pkg::NUM_GROUPS
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_i,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [WIDTH-1:0]        wdata_i,
    output logic [WIDTH-1:0]        rdata_o,
    output logic                    rvalid_o,
    output logic [WIDTH*GROUPS-1:0] pclk_o,
    output logic                    busclk_en_o
);

    localparam int unsigned NUM_P = WIDTH * GROUPS;

    logic [NUM_P-1:0] set_mask;
    logic [NUM_P-1:0] clr_mask;
    logic [NUM_P-1:0] gate_state;
    logic             bus_we;
    logic             bus_wd;

    pcg_access #(.WIDTH(WIDTH), .GROUPS(GROUPS)) u_access (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .state_i  (gate_state),
        .bus_i    (busclk_en_o),
        .set_o    (set_mask),
        .clr_o    (clr_mask),
        .bus_we_o (bus_we),
        .bus_wd_o (bus_wd),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    pcg_gate_regs #(.NUM_P(NUM_P)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (set_mask),
        .clr_i    (clr_mask),
        .bus_we_i (bus_we),
        .bus_wd_i (bus_wd),
        .state_o  (gate_state),
        .bus_o    (busclk_en_o)
    );

    for (genvar i = 0; i < NUM_P; i++) begin : g_gate
        pcg_clk_gate u_gate (
            .clk_i  (clk_i),
            .en_i   (gate_state[i]),
            .gclk_o (pclk_o[i])
        );
    end

endmodule

// File: rtl/pclk_gate_bank_chk.sv
module pclk_gate_bank_chk
    import pcg_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned GROUPS = 2
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    req_i,
    input logic                    we_i,
    input logic [ADDR_W-1:0]       addr_i,
    input logic [WIDTH-1:0]        wdata_i,
    input logic                    rvalid_o,
    input logic [WIDTH*GROUPS-1:0] pclk_o,
    input logic                    busclk_en_o,
    input logic [WIDTH*GROUPS-1:0] gate_state
);

    logic wr_en_lo, wr_dis_lo, wr_ro;
    assign wr_en_lo  = req_i && we_i && (addr_i == A_EN_LO);
    assign wr_dis_lo = req_i && we_i && (addr_i == A_DIS_LO);
    assign wr_ro     = req_i && we_i &&
                       (addr_i == A_STAT_LO || addr_i == A_STAT_HI || addr_i == A_SPARE);

    p_enable_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_lo |=> ((gate_state[WIDTH-1:0] & $past(wdata_i)) == $past(wdata_i)));

    p_disable_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_dis_lo |=> ((gate_state[WIDTH-1:0] & $past(wdata_i)) == '0));

    p_read_answers_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i) |=> rvalid_o);

    p_status_readonly_r5_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ro |=> ($stable(gate_state) && $stable(busclk_en_o)));

    p_gclk_low_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pclk_o == '0);

    p_bus_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == A_BUSCLK) |=> (busclk_en_o == $past(wdata_i[0])));

    p_write_no_rvalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i) |=> !rvalid_o);

endmodule

bind pclk_gate_bank pclk_gate_bank_chk #(.WIDTH(WIDTH), .GROUPS(GROUPS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rvalid_o    (rvalid_o),
    .pclk_o      (pclk_o),
    .busclk_en_o (busclk_en_o),
    .gate_state  (gate_state)
);

// File: tb/pclk_gate_bank_bench.sv
module pclk_gate_bank_bench;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        req   = 1'b0;
    logic        we    = 1'b0;
    logic [2:0]  addr  = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [63:0] pclk;
    logic        busclk;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // Reference model: gate state, previous-edge state, bus bit, read response
    logic [63:0] m_on   = '0;
    logic [63:0] m_prev = '0;
    logic        m_bus  = 1'b0;
    logic        m_rv   = 1'b0;
    logic [31:0] m_rd   = '0;

    always #2 clk = ~clk;   // 250 MHz

    pclk_gate_bank u_pclk_gate_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .rvalid_o    (rvalid),
        .pclk_o      (pclk),
        .busclk_en_o (busclk)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd4:    return m_on[31:0];
            3'd5:    return m_on[63:32];
            3'd6:    return {31'd0, m_bus};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = '0; m_prev = '0; m_bus = 1'b0; m_rv = 1'b0; m_rd = '0;
        end else begin
            m_prev = m_on;
            m_rv   = 1'b0;
            if (req && we) begin
                case (addr)
                    3'd0: m_on[31:0]  = m_on[31:0]  | wdata;
                    3'd1: m_on[63:32] = m_on[63:32] | wdata;
                    3'd2: m_on[31:0]  = m_on[31:0]  & ~wdata;
                    3'd3: m_on[63:32] = m_on[63:32] & ~wdata;
                    3'd6: m_bus = wdata[0];
                    default: ;
                endcase
            end else if (req) begin
                m_rv = 1'b1;
                m_rd = model_read(addr);
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // High-phase and edge-related checks
    always @(posedge clk) begin
        #1;
        if (!done) begin
            if (!rst_n) begin
                check(pclk == '0 && !rvalid && !busclk, "R1", {pclk[62:0], rvalid}, 64'd0);
            end else begin
                check(pclk == m_prev, "R7", pclk, m_prev);
                check(busclk == m_bus, "R8", {63'd0, busclk}, {63'd0, m_bus});
                check(rvalid == m_rv, "R10", {63'd0, rvalid}, {63'd0, m_rv});
                if (m_rv) check(rdata == m_rd, tag, {32'd0, rdata}, {32'd0, m_rd});
            end
        end
    end

    // Low-phase check
    always @(negedge clk) begin
        #1;
        if (!done) check(pclk == '0, "R6", pclk, 64'd0);
    end

    task automatic op(input bit w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req = 1'b0; we = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        op(0, 3'd4, 0); op(0, 3'd5, 0); op(0, 3'd6, 0); idle(2);

        // R2: set via enable words, zeros ignored
        tag = "R2";
        op(1, 3'd0, 32'h0000_00A5); op(0, 3'd4, 0);
        op(1, 3'd1, 32'h8000_0001); op(0, 3'd5, 0);
        op(1, 3'd0, 32'h0); op(0, 3'd4, 0); idle(3);

        // R3: clear via disable words, zeros ignored
        tag = "R3";
        op(1, 3'd2, 32'h0000_0005); op(0, 3'd4, 0);
        op(1, 3'd3, 32'h0); op(0, 3'd5, 0);
        op(1, 3'd3, 32'h8000_0000); op(0, 3'd5, 0); idle(3);

        // R5: status words read-only, enable/disable read zero
        tag = "R5";
        op(1, 3'd4, 32'hFFFF_FFFF); op(1, 3'd5, 32'hFFFF_FFFF);
        op(0, 3'd4, 0); op(0, 3'd5, 0);
        op(0, 3'd0, 0); op(0, 3'd1, 0); op(0, 3'd2, 0); op(0, 3'd3, 0); idle(2);

        // R8: bus clock control bit
        tag = "R8";
        op(1, 3'd6, 32'hFFFF_FFFF); op(0, 3'd6, 0);
        op(1, 3'd6, 32'hFFFF_FFFE); op(0, 3'd6, 0); idle(2);

        // R9: unmapped address
        tag = "R9";
        op(1, 3'd7, 32'hFFFF_FFFF); op(0, 3'd7, 0); op(0, 3'd4, 0); idle(2);

        // R7: enable then disable on adjacent edges, both groups
        tag = "R7";
        op(1, 3'd0, 32'h0000_0100); op(1, 3'd2, 32'h0000_0100); idle(3);
        op(1, 3'd3, 32'hFFFF_FFFF); op(1, 3'd1, 32'h0000_8000);
        op(1, 3'd3, 32'h0000_8000); op(1, 3'd1, 32'h0000_8000); idle(4);

        // R4: write followed by immediate read, back-to-back reads
        tag = "R4";
        op(1, 3'd0, 32'hDEAD_BEEF); op(0, 3'd4, 0); op(0, 3'd4, 0);
        op(1, 3'd2, 32'h0F0F_0F0F); op(0, 3'd4, 0); op(0, 3'd5, 0); idle(2);

        // Random mix of every address
        tag = "R4";
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 4) == 0) idle(1);
            else op(bit'($urandom % 2), 3'($urandom % 8), $urandom);
        end
        idle(4);

        // R1: reset mid-run clears state
        tag = "R1";
        op(1, 3'd0, 32'hFFFF_FFFF); op(1, 3'd6, 32'h1); idle(1);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        op(0, 3'd4, 0); op(0, 3'd6, 0); idle(3);

        finish_run();
    end

endmodule